// File: doc/BRIEF.md
# Optimal Filter Energy and Timing Engine

This block reduces each triggered window of five digitized samples from one calorimeter channel to three numbers. The first is the deposited energy, a weighted sum of the pedestal-subtracted samples. The second is an energy-weighted timing term, a sum over the same samples with a second weight set. The third is a quality factor, the sum of squared residuals between the samples and a reference pulse shape scaled by the measured energy. The timing and quality terms are computed only when the energy is strictly above a per-channel threshold. Dividing the timing term by the energy to get a time is left to later logic.

Each channel has its own three weight sets, pedestal and threshold, loaded at run time through a single-word write port. Triggered windows arrive at a low rate, so one signed 18x18 multiplier is shared by every product. The multiplier is registered, and its output feeds three accumulators and a residual store. The block takes one window at a time and holds `ready` low until that window's result has been presented.

Top module: `ofc_engine`

## Requirements
- R1: After reset `ready` is 1 and `res_valid` is 0. `res_energy`, `res_timing`, `res_quality`, `res_below` and `res_sat` are all 0.
- R2: A write with `cfg_we` high stores into the channel given by `cfg_chan`. `cfg_sel` picks the target. Selectors 0..4 hold the energy weights a0..a4, 5..9 the timing weights b0..b4 and 10..14 the shape weights g0..g4. Each weight is the low 18 bits of `cfg_wdata`, read as signed with 12 fractional bits. Selector 15 holds the pedestal (the low 16 bits) and selector 16 the threshold (all 32 bits, signed). Writes to any other selector change nothing.
- R3: Sample i is `win_samples[16*i +: 16]` and is unsigned. With d_i = S_i − pedestal, the energy accumulator is ΣA = Σ a_i·d_i, computed without loss in 48 bits. `res_energy` is ΣA clipped to the signed 32-bit range.
- R4: If ΣA > threshold (strictly), the timing and quality terms are produced and `res_below` is 0. Otherwise `res_timing` and `res_quality` are 0 and `res_below` is 1.
- R5: `res_timing` is Σ b_i·d_i, clipped to the signed 32-bit range.
- R6: Let e = (ΣA >>> 12) clipped to the signed 18-bit range. For each i, r_i = d_i − ((e·g_i) >>> 12), clipped to the signed 18-bit range. `res_quality` is Σ r_i², clipped to the unsigned 32-bit range. Both shifts are arithmetic.
- R7: `res_sat` is 1 when the energy is clipped, or when the result is above threshold and the timing or quality output is clipped.
- R8: Counting the accepting clock edge as edge 0, the result is presented after edge 26 when above threshold and after edge 8 otherwise. `res_valid` is high for exactly one cycle, and `res_chan` carries the window's channel.
- R9: A window is taken at an edge where `win_valid` and `ready` are both 1. `ready` then stays 0 until the result is presented. Windows offered while `ready` is 0 are dropped and produce no result.
- R10: Each channel's weights, pedestal and threshold apply only to windows of that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 2 | Channel being configured |
| cfg_sel | input | 5 | Selects a weight, the pedestal or the threshold |
| cfg_wdata | input | 32 | Configuration value |
| win_valid | input | 1 | A sample window is offered |
| win_chan | input | 2 | Channel of the offered window |
| win_samples | input | 80 | Five unsigned 16-bit samples, sample 0 in the low bits |
| ready | output | 1 | The engine can take a window |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | 2 | Channel of the result |
| res_energy | output | 32 | Saturated energy sum, signed |
| res_timing | output | 32 | Saturated timing sum, signed, zero when below threshold |
| res_quality | output | 32 | Saturated quality factor, unsigned, zero when below threshold |
| res_below | output | 1 | Energy did not exceed the threshold |
| res_sat | output | 1 | An output was clipped |

## Verification
A result is due 26 edges after its window is accepted when the energy is above threshold, and 8 edges after when it is not. The early result comes from skipping the timing, shape and quality passes. The driver records the edge count at acceptance into each scoreboard entry. The monitor samples on the falling edge and checks that the edge count at `res_valid` matches the latency the reference model predicts for that window. A result that arrives early, late or with no pending entry therefore fails, and so does a window wrongly accepted while busy.

// File: rtl/ofc_pkg.sv
package ofc_pkg;

  // Which quantity the shared multiplier is working on
  typedef enum logic [1:0] {
    PH_E = 2'd0,   // energy weights x differences
    PH_T = 2'd1,   // timing weights x differences
    PH_G = 2'd2,   // clipped energy x shape weights
    PH_Q = 2'd3    // residual squares
  } phase_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_DRAIN,
    ST_DECIDE,
    ST_FIN
  } state_t;

endpackage

// File: rtl/ofc_coef_bank.sv
module ofc_coef_bank #(
  parameter int NCH    = 4,
  parameter int NTAP   = 5,
  parameter int COEF_W = 18,
  parameter int SAMP_W = 16,
  parameter int OUT_W  = 32,
  parameter int CH_W   = $clog2(NCH),
  parameter int NCOEF  = 3 * NTAP,
  parameter int IDX_W  = $clog2(NCOEF),
  parameter int SEL_W  = $clog2(NCOEF + 2)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [CH_W-1:0]          cfg_chan,
  input  logic [SEL_W-1:0]         cfg_sel,
  input  logic [OUT_W-1:0]         cfg_wdata,
  input  logic [CH_W-1:0]          rd_chan,
  input  logic [IDX_W-1:0]         rd_idx,
  input  logic [CH_W-1:0]          ped_chan,
  output logic signed [COEF_W-1:0] rd_coef,
  output logic [SAMP_W-1:0]        ped,
  output logic signed [OUT_W-1:0]  thr
);

  localparam int ADDR_W = $clog2(NCH * NCOEF);
  localparam logic [SEL_W-1:0] SEL_PED = SEL_W'(NCOEF);
  localparam logic [SEL_W-1:0] SEL_THR = SEL_W'(NCOEF + 1);

  // Weight store: no reset so it maps to distributed or block RAM
  logic signed [COEF_W-1:0] mem [NCH*NCOEF];
  logic [SAMP_W-1:0]        ped_q [NCH];
  logic signed [OUT_W-1:0]  thr_q [NCH];
  logic [ADDR_W-1:0]        wr_addr, rd_addr;

  assign wr_addr = ADDR_W'(cfg_chan) * ADDR_W'(NCOEF) + ADDR_W'(cfg_sel);
  assign rd_addr = ADDR_W'(rd_chan) * ADDR_W'(NCOEF) + ADDR_W'(rd_idx);

  always_ff @(posedge clk) begin
    if (cfg_we && (cfg_sel < SEL_PED))
      mem[wr_addr] <= cfg_wdata[COEF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        ped_q[c] <= '0;
        thr_q[c] <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_sel == SEL_PED) ped_q[cfg_chan] <= cfg_wdata[SAMP_W-1:0];
      if (cfg_sel == SEL_THR) thr_q[cfg_chan] <= cfg_wdata;
    end
  end

  assign rd_coef = (rd_idx < IDX_W'(NCOEF)) ? mem[rd_addr] : '0;
  assign ped     = ped_q[ped_chan];
  assign thr     = thr_q[rd_chan];

endmodule

// File: rtl/ofc_seq.sv
module ofc_seq
  import ofc_pkg::*;
#(
  parameter int NTAP  = 5,
  parameter int CNT_W = $clog2(NTAP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_valid,
  input  logic             above,
  output logic             ready,
  output logic             load,
  output logic             issue,
  output phase_t           phase,
  output logic [CNT_W-1:0] idx,
  output logic             fin
);

  state_t           state;
  logic [CNT_W-1:0] cnt;

  assign ready = (state == ST_IDLE);
  assign load  = win_valid && ready;
  assign issue = (state == ST_ISSUE);
  assign idx   = cnt;
  assign fin   = (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      phase <= PH_E;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (load) begin
          state <= ST_ISSUE;
          phase <= PH_E;
          cnt   <= '0;
        end
        ST_ISSUE: begin
          if (cnt == CNT_W'(NTAP - 1)) begin
            state <= ST_DRAIN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DRAIN: begin
          unique case (phase)
            PH_E: state <= ST_DECIDE;
            PH_T: begin state <= ST_ISSUE; phase <= PH_G; end
            PH_G: begin state <= ST_ISSUE; phase <= PH_Q; end
            default: state <= ST_FIN;
          endcase
        end
        ST_DECIDE: begin
          if (above) begin
            state <= ST_ISSUE;
            phase <= PH_T;
          end else begin
            state <= ST_FIN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (win_valid && ready) |=> !ready); // R9

endmodule

// File: rtl/ofc_datapath.sv
module ofc_datapath
  import ofc_pkg::*;
#(
  parameter int NTAP   = 5,
  parameter int SAMP_W = 16,
  parameter int COEF_W = 18,
  parameter int FRAC   = 12,
  parameter int ACC_W  = 48,
  parameter int CNT_W  = $clog2(NTAP)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [NTAP*SAMP_W-1:0]   samples,
  input  logic [SAMP_W-1:0]        ped,
  input  logic                     issue,
  input  phase_t                   iss_phase,
  input  logic [CNT_W-1:0]         iss_idx,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [ACC_W-1:0]  acc_e,
  output logic signed [ACC_W-1:0]  acc_t,
  output logic signed [ACC_W-1:0]  acc_q
);

  localparam int DIFF_W = SAMP_W + 1;
  localparam int PROD_W = 2 * COEF_W;
  localparam logic signed [ACC_W-1:0] C_MAX =
    {{(ACC_W-COEF_W+1){1'b0}}, {(COEF_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] C_MIN = ~C_MAX;

  logic signed [DIFF_W-1:0] d_q [NTAP];
  logic signed [COEF_W-1:0] r_q [NTAP];

  logic signed [ACC_W-1:0]  e_shift, p_ext, d_w, res_w;
  logic signed [COEF_W-1:0] e_clip, r_clip, d_op, op_x, op_y;

  logic                     p_vld;
  phase_t                   p_ph;
  logic [CNT_W-1:0]         p_idx;
  logic signed [PROD_W-1:0] p_prod;

  // Energy in sample units, clipped to the multiplier operand range
  always_comb begin
    e_shift = acc_e >>> FRAC;
    if (e_shift > C_MAX)      e_clip = C_MAX[COEF_W-1:0];
    else if (e_shift < C_MIN) e_clip = C_MIN[COEF_W-1:0];
    else                      e_clip = e_shift[COEF_W-1:0];
  end

  // Operand selection for the shared multiplier
  always_comb begin
    d_op = {{(COEF_W-DIFF_W){d_q[iss_idx][DIFF_W-1]}}, d_q[iss_idx]};
    unique case (iss_phase)
      PH_E, PH_T: begin op_x = coef;   op_y = d_op;   end
      PH_G:       begin op_x = e_clip; op_y = coef;   end
      default:    begin op_x = r_q[iss_idx]; op_y = r_q[iss_idx]; end
    endcase
  end

  // Residual of one sample against the scaled shape
  always_comb begin
    p_ext = {{(ACC_W-PROD_W){p_prod[PROD_W-1]}}, p_prod};
    d_w   = {{(ACC_W-DIFF_W){d_q[p_idx][DIFF_W-1]}}, d_q[p_idx]};
    res_w = d_w - (p_ext >>> FRAC);
    if (res_w > C_MAX)      r_clip = C_MAX[COEF_W-1:0];
    else if (res_w < C_MIN) r_clip = C_MIN[COEF_W-1:0];
    else                    r_clip = res_w[COEF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_vld  <= 1'b0;
      p_ph   <= PH_E;
      p_idx  <= '0;
      p_prod <= '0;
      acc_e  <= '0;
      acc_t  <= '0;
      acc_q  <= '0;
      for (int i = 0; i < NTAP; i++) begin
        d_q[i] <= '0;
        r_q[i] <= '0;
      end
    end else begin
      p_vld  <= issue;
      p_ph   <= iss_phase;
      p_idx  <= iss_idx;
      p_prod <= op_x * op_y;
      if (load) begin
        acc_e <= '0;
        acc_t <= '0;
        acc_q <= '0;
        for (int i = 0; i < NTAP; i++) begin
          d_q[i] <= $signed({1'b0, samples[i*SAMP_W +: SAMP_W]}) - $signed({1'b0, ped});
          r_q[i] <= '0;
        end
      end else if (p_vld) begin
        unique case (p_ph)
          PH_E:    acc_e <= acc_e + p_ext;
          PH_T:    acc_t <= acc_t + p_ext;
          PH_G:    r_q[p_idx] <= r_clip;
          default: acc_q <= acc_q + p_ext;
        endcase
      end
    end
  end

  AST_PIPE_EMPTY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |-> !p_vld); // R8
  AST_SQUARE_NONNEG: assert property (@(posedge clk) disable iff (rst)
    (p_vld && p_ph == PH_Q) |-> !p_prod[PROD_W-1]); // R6

endmodule

// File: rtl/ofc_engine.sv
module ofc_engine
  import ofc_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int NTAP   = 5,
  parameter int SAMP_W = 16,
  parameter int COEF_W = 18,
  parameter int FRAC   = 12,
  parameter int ACC_W  = 48,
  parameter int OUT_W  = 32,
  parameter int CH_W   = $clog2(NCH),
  parameter int SEL_W  = $clog2(3 * NTAP + 2)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [CH_W-1:0]        cfg_chan,
  input  logic [SEL_W-1:0]       cfg_sel,
  input  logic [OUT_W-1:0]       cfg_wdata,
  input  logic                   win_valid,
  input  logic [CH_W-1:0]        win_chan,
  input  logic [NTAP*SAMP_W-1:0] win_samples,
  output logic                   ready,
  output logic                   res_valid,
  output logic [CH_W-1:0]        res_chan,
  output logic [OUT_W-1:0]       res_energy,
  output logic [OUT_W-1:0]       res_timing,
  output logic [OUT_W-1:0]       res_quality,
  output logic                   res_below,
  output logic                   res_sat
);

  localparam int CNT_W = $clog2(NTAP);
  localparam int NCOEF = 3 * NTAP;
  localparam int IDX_W = $clog2(NCOEF);
  localparam logic signed [ACC_W-1:0] S_MAX =
    {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] S_MIN = ~S_MAX;
  localparam logic signed [ACC_W-1:0] U_MAX =
    {{(ACC_W-OUT_W){1'b0}}, {OUT_W{1'b1}}};

  logic                     load, issue, fin, above;
  phase_t                   phase;
  logic [CNT_W-1:0]         idx;
  logic [CH_W-1:0]          chan_q;
  logic [IDX_W-1:0]         rd_idx;
  logic signed [COEF_W-1:0] coef;
  logic [SAMP_W-1:0]        ped;
  logic signed [OUT_W-1:0]  thr;
  logic signed [ACC_W-1:0]  acc_e, acc_t, acc_q, thr_ext;
  logic [OUT_W-1:0]         e_sat, t_sat, q_sat;
  logic                     e_of, t_of, q_of;

  assign rd_idx  = IDX_W'(phase) * IDX_W'(NTAP) + IDX_W'(idx);
  assign thr_ext = {{(ACC_W-OUT_W){thr[OUT_W-1]}}, thr};
  assign above   = acc_e > thr_ext;

  ofc_coef_bank #(
    .NCH(NCH), .NTAP(NTAP), .COEF_W(COEF_W), .SAMP_W(SAMP_W), .OUT_W(OUT_W),
    .CH_W(CH_W), .NCOEF(NCOEF), .IDX_W(IDX_W), .SEL_W(SEL_W)
  ) u_bank (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_chan(chan_q), .rd_idx(rd_idx), .ped_chan(win_chan),
    .rd_coef(coef), .ped(ped), .thr(thr)
  );

  ofc_seq #(.NTAP(NTAP), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .win_valid(win_valid), .above(above),
    .ready(ready), .load(load), .issue(issue), .phase(phase), .idx(idx), .fin(fin)
  );

  ofc_datapath #(
    .NTAP(NTAP), .SAMP_W(SAMP_W), .COEF_W(COEF_W), .FRAC(FRAC),
    .ACC_W(ACC_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst(rst), .load(load), .samples(win_samples), .ped(ped),
    .issue(issue), .iss_phase(phase), .iss_idx(idx), .coef(coef),
    .acc_e(acc_e), .acc_t(acc_t), .acc_q(acc_q)
  );

  // Output clipping
  always_comb begin
    e_of  = (acc_e > S_MAX) || (acc_e < S_MIN);
    e_sat = (acc_e > S_MAX) ? S_MAX[OUT_W-1:0] :
            (acc_e < S_MIN) ? S_MIN[OUT_W-1:0] : acc_e[OUT_W-1:0];
    t_of  = (acc_t > S_MAX) || (acc_t < S_MIN);
    t_sat = (acc_t > S_MAX) ? S_MAX[OUT_W-1:0] :
            (acc_t < S_MIN) ? S_MIN[OUT_W-1:0] : acc_t[OUT_W-1:0];
    q_of  = acc_q > U_MAX;
    q_sat = q_of ? U_MAX[OUT_W-1:0] : acc_q[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q      <= '0;
      res_valid   <= 1'b0;
      res_chan    <= '0;
      res_energy  <= '0;
      res_timing  <= '0;
      res_quality <= '0;
      res_below   <= 1'b0;
      res_sat     <= 1'b0;
    end else begin
      if (load) chan_q <= win_chan;
      res_valid <= fin;
      if (fin) begin
        res_chan    <= chan_q;
        res_energy  <= e_sat;
        res_timing  <= above ? t_sat : '0;
        res_quality <= above ? q_sat : '0;
        res_below   <= !above;
        res_sat     <= e_of || (above && (t_of || q_of));
      end
    end
  end

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R8
  AST_BELOW_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_below) |-> (res_timing == '0 && res_quality == '0)); // R4
  AST_READY_ON_RESULT: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ready); // R9

endmodule

// File: tb/ofc_engine_bench.sv
module ofc_engine_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_chan = '0;
  logic [4:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        win_valid = 1'b0;
  logic [1:0]  win_chan = '0;
  logic [79:0] win_samples = '0;
  logic        ready, res_valid, res_below, res_sat;
  logic [1:0]  res_chan;
  logic [31:0] res_energy, res_timing, res_quality;

  always #10 clk = ~clk;

  ofc_engine u_ofc_engine (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .win_valid(win_valid), .win_chan(win_chan),
    .win_samples(win_samples), .ready(ready), .res_valid(res_valid),
    .res_chan(res_chan), .res_energy(res_energy), .res_timing(res_timing),
    .res_quality(res_quality), .res_below(res_below), .res_sat(res_sat)
  );

  typedef struct {
    int     chan;
    longint e, t, q;
    bit     below, sat;
    int     acc_cyc;
    string  tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0, n_fail = 0, cyc = 0;
  bit   done = 1'b0;
  int   ma [4][15];
  int   mped [4];
  int   mthr [4];
  int   win [5];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint clip(input longint v, input longint lo, input longint hi);
    return (v > hi) ? hi : (v < lo) ? lo : v;
  endfunction

  function automatic longint energy_sum(input int ch);
    longint s = 0;
    for (int i = 0; i < 5; i++)
      s += longint'(ma[ch][i]) * (longint'(win[i]) - longint'(mped[ch]));
    return s;
  endfunction

  // Reference model of R3..R7
  function automatic exp_t model(input int ch);
    exp_t   x;
    longint d [5];
    longint ae = 0, at = 0, aq = 0, e18, p, r;
    bit     eo, to, qo;
    for (int i = 0; i < 5; i++) d[i] = longint'(win[i]) - longint'(mped[ch]);
    for (int i = 0; i < 5; i++) begin
      ae += longint'(ma[ch][i]) * d[i];
      at += longint'(ma[ch][5+i]) * d[i];
    end
    x.chan  = ch;
    x.below = !(ae > longint'(mthr[ch]));
    x.e     = clip(ae, -64'sd2147483648, 64'sd2147483647);
    eo      = (x.e != ae);
    e18     = clip(ae >>> 12, -64'sd131072, 64'sd131071);
    for (int i = 0; i < 5; i++) begin
      p   = e18 * longint'(ma[ch][10+i]);
      r   = clip(d[i] - (p >>> 12), -64'sd131072, 64'sd131071);
      aq += r * r;
    end
    x.t = clip(at, -64'sd2147483648, 64'sd2147483647);
    to  = (x.t != at);
    x.q = (aq > 64'sd4294967295) ? 64'sd4294967295 : aq;
    qo  = (x.q != aq);
    x.sat = eo || (!x.below && (to || qo));
    if (x.below) begin
      x.t = 0;
      x.q = 0;
    end
    return x;
  endfunction

  task automatic wait_idle();
    @(negedge clk);
    while (sb.size() != 0 || !ready) @(negedge clk);
  endtask

  task automatic cfg_write(input int ch, input int sel, input logic [31:0] wd);
    wait_idle();
    cfg_we = 1'b1; cfg_chan = 2'(ch); cfg_sel = 5'(sel); cfg_wdata = wd;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel < 15)       ma[ch][sel] = int'($signed(wd[17:0]));
    else if (sel == 15) mped[ch]    = int'({16'b0, wd[15:0]});
    else if (sel == 16) mthr[ch]    = int'(wd);
  endtask

  task automatic send(input int ch, input string tag);
    exp_t x;
    @(negedge clk);
    while (!ready) @(negedge clk);
    win_chan  = 2'(ch);
    for (int i = 0; i < 5; i++) win_samples[i*16 +: 16] = 16'(win[i]);
    win_valid = 1'b1;
    @(negedge clk);
    win_valid = 1'b0;
    x = model(ch);
    x.tag = tag;
    x.acc_cyc = cyc;
    sb.push_back(x);
  endtask

  // Monitor: compare each result with the head of the scoreboard
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R9", "unexpected result", 1, 0);
      end else begin
        exp_t x;
        x = sb.pop_front();
        chk(int'(res_chan) == x.chan, "R10", {x.tag, " channel"}, res_chan, x.chan);
        chk(longint'($signed(res_energy)) == x.e, "R3", {x.tag, " energy"},
            longint'($signed(res_energy)), x.e);
        chk(res_below == x.below, "R4", {x.tag, " below flag"}, res_below, x.below);
        chk(longint'($signed(res_timing)) == x.t, "R5", {x.tag, " timing"},
            longint'($signed(res_timing)), x.t);
        chk(longint'(res_quality) == x.q, "R6", {x.tag, " quality"},
            longint'(res_quality), x.q);
        chk(res_sat == x.sat, "R7", {x.tag, " sat flag"}, res_sat, x.sat);
        chk(cyc - x.acc_cyc == (x.below ? 8 : 26), "R8", {x.tag, " latency"},
            cyc - x.acc_cyc, x.below ? 8 : 26);
      end
    end
  end

  task automatic set_win(input int s0, input int s1, input int s2, input int s3, input int s4);
    win[0] = s0; win[1] = s1; win[2] = s2; win[3] = s3; win[4] = s4;
  endtask

  task automatic program_random(input int ch);
    for (int s = 0; s < 15; s++) cfg_write(ch, s, $urandom);
    cfg_write(ch, 15, $urandom);
    cfg_write(ch, 16, 32'($signed($urandom) >>> 3));
  endtask

  initial begin
    int a0 [5] = '{-300, 1200, 4096, 1500, -200};
    int b0 [5] = '{-800, -1500, 0, 1600, 700};
    int g0 [5] = '{410, 2048, 4096, 2600, 900};
    longint ae;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ready == 1'b1, "R1", "ready after reset", ready, 1);
    chk(res_valid == 1'b0, "R1", "res_valid after reset", res_valid, 0);
    chk(res_energy == 0 && res_timing == 0 && res_quality == 0, "R1",
        "outputs after reset", res_energy, 0);
    chk(res_below == 1'b0 && res_sat == 1'b0, "R1", "flags after reset", res_sat, 0);

    // R2: program channel 0 through the write map
    for (int i = 0; i < 5; i++) begin
      cfg_write(0, i, 32'(a0[i]));
      cfg_write(0, 5 + i, 32'(b0[i]));
      cfg_write(0, 10 + i, 32'(g0[i]));
    end
    cfg_write(0, 15, 32'd100);
    cfg_write(0, 16, 32'd1000);
    set_win(120, 900, 2500, 1800, 400);
    send(0, "R2 R3 above");
    set_win(100, 100, 100, 100, 100);
    send(0, "R4 below");

    // R4 boundary: threshold equal to the energy is below, one less is above
    set_win(150, 700, 1900, 1300, 350);
    ae = energy_sum(0);
    cfg_write(0, 16, 32'(ae));
    send(0, "R4 equal");
    cfg_write(0, 16, 32'(ae - 1));
    send(0, "R4 one below");

    // R2: writes to unmapped selectors change nothing
    for (int s = 17; s < 32; s++) cfg_write(0, s, 32'hDEAD_BEEF);
    send(0, "R2 unmapped");

    // R7: saturation of energy, timing and quality
    for (int i = 0; i < 5; i++) begin
      cfg_write(1, i, 32'd131071);
      cfg_write(1, 5 + i, 32'd131071);
      cfg_write(1, 10 + i, 32'd4096);
    end
    cfg_write(1, 15, 32'd0);
    cfg_write(1, 16, 32'h8000_0000);
    set_win(65535, 65535, 65535, 65535, 65535);
    send(1, "R7 positive sat");
    for (int i = 0; i < 5; i++) cfg_write(1, i, 32'hFFFE_0000);
    send(1, "R7 negative sat");

    // R10: two channels with different sets, same window, interleaved
    program_random(2);
    program_random(3);
    set_win(3000, 12000, 40000, 22000, 6000);
    send(2, "R10 ch2");
    send(3, "R10 ch3");
    send(2, "R10 ch2 again");

    // R9: windows offered while busy are dropped
    set_win(120, 900, 2500, 1800, 400);
    cfg_write(0, 16, 32'd1000);
    send(0, "R9 busy");
    win_valid = 1'b1; win_chan = 2'd3;
    for (int k = 0; k < 5; k++) begin
      chk(ready == 1'b0, "R9", "ready low while busy", ready, 0);
      @(negedge clk);
    end
    win_valid = 1'b0;

    // Random windows and weight sets
    for (int n = 0; n < 48; n++) begin
      if (n % 8 == 0) program_random(n % 4);
      for (int i = 0; i < 5; i++) win[i] = int'($urandom & 32'hFFFF);
      send(int'($urandom % 4), "R3 R5 R6 random");
    end

    wait_idle();
    repeat (30) @(negedge clk);
    chk(sb.size() == 0, "R8", "pending results at end", sb.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R8", "watchdog expired", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule